// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

This block is a single-port synchronous SRAM model. The address, the control inputs and the write data are all sampled on the rising clock edge. Read data passes through an output register, so it is available one cycle after the address that selects it. A 36-bit word is made of four 9-bit lanes, which hold 32 data bits and 4 parity bits. The array is a small register memory whose depth is set by a parameter.

A two-bit burst counter lets one loaded address produce four beats. While the advance input is held low, the counter steps once per edge. It walks the four words of the loaded address's aligned block in one of two orders: linear increment or XOR. The counter always stays inside that block. Either of two address strobes can load an address. The processor strobe has priority and always starts a read. A load through the controller strobe can write on the same edge. Later edges read or write depending on the write-enable inputs sampled on those edges.

A global write stores a whole word. A byte-write enable with per-lane selects stores only the chosen lanes. A sleep input stops all accesses. The output is switched off by deselection, by the output enable, or by sleep.

Top module: `pburst_sram`

## Requirements
- R1: After reset, `q_oe` is 0 and `rdata` is all zeros.
- R2: A load happens when `proc_strobe_n` or `ctrl_strobe_n` is low at an edge while `ce_n`, `sel0_n` and `sel1_n` are all low and `sleep` is 0. If `proc_strobe_n` is low, the access is a read even when write inputs are asserted. A load through `ctrl_strobe_n` alone with no write intent is also a read.
- R3: Read data for the address loaded at edge E0 appears on `rdata`, with `q_oe`=1, after edge E1.
- R4: With `burst_order`=0, beat k (k=0..3) reads the address whose upper bits equal the loaded address and whose two low bits are (A[1:0]+k) mod 4.
- R5: With `burst_order`=1, beat k uses the low bits A[1:0] XOR k, with the upper bits unchanged.
- R6: While `step_n` is high on edges with no strobe, the beat address holds and the same word is output again.
- R7: After the fourth beat, a further step returns to the first beat address and never leaves the four-word block.
- R8: With `all_wr_n`=0, all four lanes of the current beat address take `wdata`, whatever the lane selects are.
- R9: With `all_wr_n`=1 and `lane_wr_en_n`=0, lane i (bits 9i+8..9i) is written only when `lane_sel_n[i]`=0. With both `all_wr_n` and `lane_wr_en_n` high, nothing is written.
- R10: A load through `ctrl_strobe_n` with write intent writes `wdata` to the loaded address on that edge. Later strobe-free edges with write intent write to the successive beat addresses.
- R11: A strobe while any of `ce_n`, `sel0_n`, `sel1_n` is high deselects the device and loads nothing. `q_oe` is 0 from the second edge counted from the deselecting edge.
- R12: While `oe_n`=1, `q_oe` is 0 and `rdata` is zero at once. Data returns as soon as `oe_n` falls.
- R13: While `sleep`=1, `q_oe` is 0 and no write occurs. A sleep edge ends any burst in progress.
- R14: A read of an address that was written on an earlier edge returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address sampled on a load |
| ce_n | input | 1 | Chip enable, active low |
| sel0_n | input | 1 | First chip select, active low |
| sel1_n | input | 1 | Second chip select, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low, priority, read |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| burst_order | input | 1 | 0 = linear beat order, 1 = XOR beat order |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Power-down, active high |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| q_oe | output | 1 | High while rdata is driven (low = high impedance) |

## Verification
The bench uses the default build: 6 address bits (64 words) and four 9-bit lanes. At this size every word can be written by controller-strobe write bursts, and a read burst can then start from each of the 64 addresses in both beat orders. That covers every starting offset inside a block, every wrap-around and both strobes. The lane tests use chosen select patterns. The deselect test takes each of the three select inputs high in turn.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } beat_order_e;

  localparam int unsigned BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] base,
                                                 input logic [BEAT_W-1:0] k,
                                                 input beat_order_e ord);
    return (ord == ORD_XOR) ? (base ^ k) : (base + k);
  endfunction
endpackage

// File: rtl/burst_ctr.sv
module burst_ctr
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              step,
  input  logic              order,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] now_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] k_q, k_d, k_inc, k_use;
  beat_order_e       ord;

  assign ord      = beat_order_e'(order);
  assign k_inc    = k_q + 2'd1;
  assign k_use    = step ? k_inc : k_q;
  assign cur_addr = {base_q[ADDR_W-1:BEAT_W], beat_low(base_q[BEAT_W-1:0], k_q, ord)};
  assign now_addr = load ? load_addr
                         : {base_q[ADDR_W-1:BEAT_W], beat_low(base_q[BEAT_W-1:0], k_use, ord)};

  always_comb begin
    base_d = base_q;
    k_d    = k_q;
    if (load) begin
      base_d = load_addr;
      k_d    = '0;
    end else if (step) begin
      k_d = k_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      k_q    <= '0;
    end else if (en) begin
      base_q <= base_d;
      k_q    <= k_d;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !step) |=> ($stable(k_q) && $stable(base_q)));

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (base_q == $past(base_q)));
endmodule

// File: rtl/lane_wr_dec.sv
module lane_wr_dec #(
  parameter int unsigned LANES = 4
) (
  input  logic             go,
  input  logic             all_n,
  input  logic             lanes_en_n,
  input  logic [LANES-1:0] sel_n,
  output logic             intent,
  output logic [LANES-1:0] we
);
  assign intent = !all_n || (!lanes_en_n && (sel_n != {LANES{1'b1}}));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign we[i] = go && (!all_n || (!lanes_en_n && !sel_n[i]));
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) bank[waddr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] = bank[raddr];

    assert_lane_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      we[i] |=> (bank[$past(waddr)] == $past(wdata[i*LANE_W +: LANE_W])));
  end
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce_n,
  input  logic                    sel0_n,
  input  logic                    sel1_n,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    step_n,
  input  logic                    burst_order,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    q_oe
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic selected, strobe, awake, load, desel, intent, wr_go, ctr_step;
  logic active_q, active_d, rd_q, rd_d, drv_q, drv_d;
  logic [WORD_W-1:0] q_q, q_d, arr_rd;
  logic [ADDR_W-1:0] now_addr, cur_addr;
  logic [LANES-1:0]  lane_we;

  assign awake    = !sleep;
  assign selected = !ce_n && !sel0_n && !sel1_n;
  assign strobe   = !proc_strobe_n || !ctrl_strobe_n;
  assign load     = awake && strobe && selected;
  assign desel    = awake && strobe && !selected;
  assign wr_go    = awake && intent &&
                    ((load && proc_strobe_n) || (!strobe && active_q));
  assign ctr_step = !step_n && active_q && !strobe;

  burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (awake),
    .load      (load),
    .step      (ctr_step),
    .order     (burst_order),
    .load_addr (addr),
    .now_addr  (now_addr),
    .cur_addr  (cur_addr)
  );

  lane_wr_dec #(.LANES(LANES)) u_dec (
    .go         (wr_go),
    .all_n      (all_wr_n),
    .lanes_en_n (lane_wr_en_n),
    .sel_n      (lane_sel_n),
    .intent     (intent),
    .we         (lane_we)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lane_we),
    .waddr (now_addr),
    .wdata (wdata),
    .raddr (cur_addr),
    .rdata (arr_rd)
  );

  always_comb begin
    active_d = active_q;
    rd_d     = rd_q;
    if (!awake || desel) begin
      active_d = 1'b0;
      rd_d     = 1'b0;
    end else if (load) begin
      active_d = 1'b1;
      rd_d     = !wr_go;
    end else if (active_q) begin
      rd_d = !wr_go;
    end else begin
      rd_d = 1'b0;
    end
    drv_d = rd_q;
    q_d   = rd_q ? arr_rd : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      drv_q    <= 1'b0;
      q_q      <= '0;
    end else begin
      active_q <= active_d;
      rd_q     <= rd_d;
      drv_q    <= drv_d;
      if (rd_q) q_q <= q_d;
    end
  end

  assign q_oe  = drv_q && !oe_n && awake;
  assign rdata = q_oe ? q_q : '0;

  assert_desel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    desel |-> ##2 !q_oe);

  assert_sleep_R13: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0) && !q_oe && (rdata == '0));
endmodule

// File: tb/tb_pburst_sram.sv
module tb_pburst_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic ce_n, sel0_n, sel1_n, proc_strobe_n, ctrl_strobe_n, step_n, burst_order;
  logic all_wr_n, lane_wr_en_n, oe_n, sleep;
  logic [NL-1:0] lane_sel_n;
  logic [WW-1:0] wdata, rdata;
  logic q_oe;

  logic [WW-1:0] model [64];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .step_n(step_n),
    .burst_order(burst_order), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .q_oe(q_oe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; step_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = '1;
    ce_n = 1'b0; sel0_n = 1'b0; sel1_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
  endtask

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] a, input int k, input logic ord);
    logic [1:0] kk;
    kk = 2'(k);
    return ord ? {a[AW-1:2], a[1:0] ^ kk} : {a[AW-1:2], a[1:0] + kk};
  endfunction

  function automatic logic [WW-1:0] pat(input int a, input int salt);
    return WW'(a) * 36'h0_9E37_79B1 + WW'(salt) * 36'h1_0000_0101;
  endfunction

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old, input logic [WW-1:0] nw,
                                         input logic gw, input logic bwe, input logic [NL-1:0] sel);
    logic [WW-1:0] r;
    r = old;
    for (int i = 0; i < NL; i++)
      if (!gw || (!bwe && !sel[i])) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic rd_burst(input logic [AW-1:0] a, input logic ord, input bit use_ctrl);
    idle();
    addr = a; burst_order = ord;
    if (use_ctrl) ctrl_strobe_n = 1'b0; else proc_strobe_n = 1'b0;
    tick();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; step_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (i == 0) chk("R3 q_oe", WW'(q_oe), WW'(1));
      chk(i == 4 ? "R7 wrap" : (ord ? "R5 xor beat" : "R4 linear beat"),
          rdata, model[baddr(a, i % 4, ord)]);
    end
    step_n = 1'b1;
  endtask

  task automatic lane_case(input logic [AW-1:0] a, input logic gw, input logic bwe,
                           input logic [NL-1:0] sel, input logic [WW-1:0] w, input string req);
    idle();
    addr = a; proc_strobe_n = 1'b0; burst_order = 1'b0;
    tick();
    proc_strobe_n = 1'b1;
    all_wr_n = gw; lane_wr_en_n = bwe; lane_sel_n = sel; wdata = w;
    tick();
    model[a] = merge(model[a], w, gw, bwe, sel);
    idle();
    addr = a; proc_strobe_n = 1'b0;
    tick();
    proc_strobe_n = 1'b1;
    tick();
    chk(req, rdata, model[a]);
  endtask

  initial begin
    logic [AW-1:0] s, a;
    rst_n = 1'b0; addr = '0; wdata = '0; burst_order = 1'b0;
    idle();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 q_oe", WW'(q_oe), WW'(0));
    chk("R1 rdata", rdata, '0);

    // R10 and R8: fill the array with controller-strobe write bursts
    for (int b = 0; b < 16; b++) begin
      s = AW'(4 * b + (b % 4));
      idle();
      addr = s; ctrl_strobe_n = 1'b0; all_wr_n = 1'b0; lane_sel_n = 4'b0101;
      wdata = pat(s, 1); burst_order = 1'b0;
      tick();
      model[s] = wdata;
      ctrl_strobe_n = 1'b1; step_n = 1'b0;
      for (int k = 1; k < 4; k++) begin
        a = baddr(s, k, 1'b0);
        wdata = pat(a, 1);
        tick();
        model[a] = wdata;
      end
    end

    // R4 R5 R7 R2 R3: bursts from every address in both orders
    for (int i = 0; i < 64; i++) rd_burst(AW'(i), 1'b0, 1'b0);
    for (int i = 0; i < 64; i++) rd_burst(AW'(i), 1'b1, 1'b1);

    // R6: hold while step_n is high
    idle(); addr = 6'd13; burst_order = 1'b0; proc_strobe_n = 1'b0;
    tick();
    proc_strobe_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 hold", rdata, model[13]);
    end
    step_n = 1'b0;
    tick(); chk("R6 resume", rdata, model[13]);
    tick(); chk("R6 resume next", rdata, model[baddr(6'd13, 1, 1'b0)]);

    // R9 and R8: lane writes
    lane_case(6'd20, 1'b1, 1'b0, 4'b1010, pat(99, 7), "R9 lanes 0,2");
    lane_case(6'd21, 1'b1, 1'b0, 4'b0111, pat(98, 3), "R9 lane 3");
    lane_case(6'd22, 1'b1, 1'b1, 4'b0000, pat(97, 5), "R9 no write");
    lane_case(6'd23, 1'b0, 1'b1, 4'b1111, pat(96, 9), "R8 global");

    // R14: controller write then immediate read of the same address
    idle(); addr = 6'd33; ctrl_strobe_n = 1'b0; all_wr_n = 1'b0; wdata = pat(33, 44);
    tick();
    model[33] = wdata;
    idle(); addr = 6'd33; proc_strobe_n = 1'b0;
    tick();
    proc_strobe_n = 1'b1;
    tick();
    chk("R14 read after write", rdata, model[33]);

    // R2: processor strobe wins and is a read
    idle(); addr = 6'd40; proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0;
    all_wr_n = 1'b0; wdata = pat(1, 1234);
    tick();
    idle();
    tick(); chk("R2 priority read", rdata, model[40]);
    tick(); chk("R2 no write", rdata, model[40]);

    // R11: deselect through each select input
    for (int sidx = 0; sidx < 3; sidx++) begin
      idle(); addr = 6'd50; proc_strobe_n = 1'b0;
      tick();
      proc_strobe_n = 1'b1; step_n = 1'b0;
      tick();
      chk("R11 before", WW'(q_oe), WW'(1));
      step_n = 1'b1; proc_strobe_n = 1'b0; addr = 6'd3;
      ce_n = (sidx == 0); sel0_n = (sidx == 1); sel1_n = (sidx == 2);
      tick();
      idle();
      tick();
      chk("R11 q_oe off", WW'(q_oe), WW'(0));
      chk("R11 rdata zero", rdata, '0);
      tick();
      chk("R11 stays off", WW'(q_oe), WW'(0));
    end

    // R12: output enable
    idle(); addr = 6'd7; proc_strobe_n = 1'b0;
    tick();
    proc_strobe_n = 1'b1;
    tick();
    chk("R12 driving", rdata, model[7]);
    oe_n = 1'b1; #1;
    chk("R12 q_oe off", WW'(q_oe), WW'(0));
    chk("R12 rdata zero", rdata, '0);
    oe_n = 1'b0; #1;
    chk("R12 back", rdata, model[7]);

    // R13: sleep
    @(negedge clk);
    idle(); addr = 6'd9; proc_strobe_n = 1'b0;
    tick();
    proc_strobe_n = 1'b1;
    tick();
    sleep = 1'b1; ctrl_strobe_n = 1'b0; all_wr_n = 1'b0; wdata = pat(5, 555); #1;
    chk("R13 q_oe off", WW'(q_oe), WW'(0));
    @(negedge clk);
    tick();
    idle();
    tick();
    chk("R13 burst ended", WW'(q_oe), WW'(0));
    idle(); addr = 6'd9; proc_strobe_n = 1'b0;
    tick();
    proc_strobe_n = 1'b1;
    tick();
    chk("R13 no write", rdata, model[9]);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule